// File: doc/BRIEF.md
# Three-Wire Configuration Port with Mode-Pin Override

This block is the configuration front end of an IF receiver subsystem. A host writes framed words over a slow three-wire serial link (clock, data, active-low enable). The block oversamples those wires with the system clock and checks each frame. A well-formed frame is written into one of seven registers: two VCO divide values, two reference-divide/charge-pump pairs, or the 13-bit control register.

From these registers and a tri-level mode pin, the block works out the effective operating controls. These are the oscillator choice, the input port choice and the divider-set choice, plus the divider values of the chosen set and the power state of the chip and of the signal path. It also issues a one-cycle turbo-acquisition start request. That request is honoured only when a control write carries the turbo bit and at least one divider write came before it. A hardware shutdown input holds every register at its default and keeps the serial port idle. The register power bit only marks the chip as powered down; the registers and the port stay alive.

Top module: `tri_wire_cfg`

## Requirements
- R1: After reset, the registers hold their defaults: control 0x0B57, first VCO divider 10519, second VCO divider 4269, both reference dividers 492, both charge-pump codes 2'b11.
- R2: A frame is 17 data bits shifted MSB first. Each bit is sampled on a rising serial clock edge while enable is low. The first bit is a start bit and must be 1. The last three bits are the address, A2 A1 A0. The register is written after enable rises. Address 3'b110 loads the control register from the 13 bits that follow the start bit.
- R3: Address bits A1A0 = 2'b00 select the first VCO divider and 2'b01 select the second. For these, the 14 bits after the start bit are the divider value, so A2 is its least significant bit.
- R4: Address 3'b010 writes the first reference pair and 3'b011 writes the second. The two bits after the start bit are the charge-pump code, and the next 11 bits are the reference divider.
- R5: A frame whose start bit is 0 changes no register.
- R6: A frame with any count other than 17 clocked bits changes no register.
- R7: A frame is accepted only if at least one serial clock rising edge occurs with enable high before enable falls. Each accepted frame needs its own such edge.
- R8: Control bit positions, from bit 0 upward: power (SD), active (SB), input select, FM I-only, buffer disable, buffer halve, oscillator select, oscillator bypass, divider-set select, turbo, test enable, pump polarity, test mode. While the mode pin is driven, the effective oscillator select, divider-set select and input select all equal the pin level. While the pin floats, they follow bits 6, 8 and 2.
- R9: When the effective divider-set select is 1, the effective divider, reference and pump outputs come from the first set. When it is 0, they come from the second set.
- R10: While hardware shutdown is low, all registers return to their defaults, frames are ignored and chip power is reported off.
- R11: Control bit 0 at 0 reports both chip and path power off but keeps the registers writable. Bit 1 at 0 with bit 0 at 1 turns off only the path.
- R12: A control write with bit 9 set pulses the turbo start for one cycle only if a divider or reference write happened since the previous control write.
- R13: Address 3'b111 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_shdn_n_i | input | 1 | Hardware shutdown, active low |
| sclk_i | input | 1 | Serial clock |
| sdata_i | input | 1 | Serial data |
| sen_n_i | input | 1 | Serial enable, active low |
| mode_drv_i | input | 1 | Mode pin is driven (0 = floating) |
| mode_lvl_i | input | 1 | Mode pin level when driven |
| ctrl_o | output | 13 | Control register |
| m1_o | output | 14 | First VCO divider |
| m2_o | output | 14 | Second VCO divider |
| r1_o | output | 11 | First reference divider |
| r2_o | output | 11 | Second reference divider |
| cp1_o | output | 2 | First charge-pump code |
| cp2_o | output | 2 | Second charge-pump code |
| m_eff_o | output | 14 | Selected VCO divider |
| r_eff_o | output | 11 | Selected reference divider |
| cp_eff_o | output | 2 | Selected charge-pump code |
| vco_hi_o | output | 1 | Effective oscillator select |
| div_set1_o | output | 1 | Effective divider-set select |
| in_cdma_o | output | 1 | Effective input select |
| fm_i_only_o | output | 1 | FM output on I path only |
| vco_bypass_o | output | 1 | External oscillator in use |
| lo_buf_on_o | output | 1 | LO buffer enabled |
| lo_half_o | output | 1 | LO buffer divides by two |
| cp_pol_o | output | 1 | Charge-pump polarity |
| chip_on_o | output | 1 | Chip powered |
| path_on_o | output | 1 | Gain stage and demodulator powered |
| turbo_start_o | output | 1 | One-cycle turbo acquisition request |

## Verification
Some properties are checked on every cycle. The first is the pin override of the three select outputs. The others are that path power implies chip power, that hardware shutdown forces defaults, that registers stay put on cycles without a frame, and that turbo starts only alongside a stored turbo bit. The bit counter bound and the single-cycle load strobe are checked the same way. Other behaviours can only be shown by whole serial transactions: rejection of bad start bits, wrong bit counts, missing initialisation and the unused address; the address-bit sharing for divider values; and the order dependence of turbo on an earlier divider write.

// File: rtl/tri_wire_cfg_pkg.sv
`timescale 1ns/1ps
// Shared widths, field layout and reset values of the configuration port.
// Assumes a 17-bit frame: start bit, 13 to 14 data bits, 3-bit address tail.
package tri_wire_cfg_pkg;
    localparam int FRAME_BITS = 17;
    localparam int PAY_W      = FRAME_BITS - 1;
    localparam int ADR_W      = 3;
    localparam int M_W        = 14;
    localparam int R_W        = 11;
    localparam int CP_W       = 2;
    localparam int CTRL_W     = 13;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);

    // Member order is MSB first, so powered lands on bit 0.
    typedef struct packed {
        logic test_mode;
        logic cp_pol;
        logic test_en;
        logic turbo;
        logic div_set1;
        logic vco_byp;
        logic vco_hi;
        logic buf_half;
        logic buf_off;
        logic fm_i_only;
        logic in_cdma;
        logic active;
        logic powered;
    } ctrl_t;

    localparam logic [CTRL_W-1:0] CTRL_DEF = 13'h0B57;
    localparam logic [M_W-1:0]    M1_DEF   = 14'd10519;
    localparam logic [M_W-1:0]    M2_DEF   = 14'd4269;
    localparam logic [R_W-1:0]    R_DEF    = 11'd492;
    localparam logic [CP_W-1:0]   CP_DEF   = 2'b11;
endpackage

// File: rtl/tri_wire_rx.sv
`timescale 1ns/1ps
// Oversamples the three serial wires and validates frames.
// Assumes the serial clock is much slower than clk; a frame is accepted
// only when armed, exactly FRAME_BITS long and its start bit is 1.
module tri_wire_rx
    import tri_wire_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_on,
    input  logic             sclk,
    input  logic             sdata,
    input  logic             sen_n,
    output logic             frame_vld,
    output logic [PAY_W-1:0] payload
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_BITS + 1);

    logic [SYNC_STAGES-1:0] sclk_sy, sdata_sy, sen_sy;
    logic                   sclk_d, sen_d;
    logic                   armed, open_q;
    logic [CNT_W-1:0]       cnt;
    logic [FRAME_BITS-1:0]  shreg;

    logic sclk_r, sdata_r, sen_r, sclk_rise, sen_rise, sen_fall;
    assign sclk_r    = sclk_sy[SYNC_STAGES-1];
    assign sdata_r   = sdata_sy[SYNC_STAGES-1];
    assign sen_r     = sen_sy[SYNC_STAGES-1];
    assign sclk_rise = sclk_r & ~sclk_d;
    assign sen_rise  = sen_r & ~sen_d;
    assign sen_fall  = ~sen_r & sen_d;
    assign payload   = shreg[PAY_W-1:0];

    // Synchroniser chains and edge-detect history; enable idles high.
    always_ff @(posedge clk) begin
        if (!rst_n || !hw_on) begin
            sclk_sy  <= '0;
            sdata_sy <= '0;
            sen_sy   <= '1;
            sclk_d   <= 1'b0;
            sen_d    <= 1'b1;
        end else begin
            sclk_sy  <= {sclk_sy[SYNC_STAGES-2:0], sclk};
            sdata_sy <= {sdata_sy[SYNC_STAGES-2:0], sdata};
            sen_sy   <= {sen_sy[SYNC_STAGES-2:0], sen_n};
            sclk_d   <= sclk_r;
            sen_d    <= sen_r;
        end
    end

    // Arming, bit shifting, counting and frame validation.
    always_ff @(posedge clk) begin
        if (!rst_n || !hw_on) begin
            armed     <= 1'b0;
            open_q    <= 1'b0;
            cnt       <= '0;
            shreg     <= '0;
            frame_vld <= 1'b0;
        end else begin
            frame_vld <= 1'b0;
            if (sen_r && sclk_rise) armed <= 1'b1;
            if (sen_fall) begin
                open_q <= armed;
                armed  <= 1'b0;
                cnt    <= '0;
            end else if (!sen_r && sclk_rise && cnt != CNT_MAX) begin
                shreg <= {shreg[FRAME_BITS-2:0], sdata_r};
                cnt   <= cnt + 1'b1;
            end
            if (sen_rise) begin
                frame_vld <= open_q && (cnt == CNT_FULL) && shreg[FRAME_BITS-1];
                open_q    <= 1'b0;
            end
        end
    end

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_MAX);
    p_load_en_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |-> sen_r);
    p_load_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |=> !frame_vld);
endmodule

// File: rtl/tri_wire_regs.sv
`timescale 1ns/1ps
// Address decode and storage of divider, pump and control registers,
// plus the turbo start qualifier. Assumes frame_vld is a one-cycle strobe.
module tri_wire_regs
    import tri_wire_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_on,
    input  logic             frame_vld,
    input  logic [PAY_W-1:0] payload,
    output ctrl_t            ctrl_q,
    output logic [M_W-1:0]   m1_q,
    output logic [M_W-1:0]   m2_q,
    output logic [R_W-1:0]   r1_q,
    output logic [R_W-1:0]   r2_q,
    output logic [CP_W-1:0]  cp1_q,
    output logic [CP_W-1:0]  cp2_q,
    output logic             turbo_q
);
    logic [ADR_W-1:0]  adr;
    logic [M_W-1:0]    f_m;
    logic [R_W-1:0]    f_r;
    logic [CP_W-1:0]   f_cp;
    ctrl_t             f_ctrl;
    logic              div_since;

    assign adr    = payload[ADR_W-1:0];
    assign f_m    = payload[PAY_W-1 -: M_W];
    assign f_r    = payload[ADR_W +: R_W];
    assign f_cp   = payload[PAY_W-1 -: CP_W];
    assign f_ctrl = ctrl_t'(payload[PAY_W-1 -: CTRL_W]);

    // Register writes by address; divider writes arm the turbo qualifier.
    always_ff @(posedge clk) begin
        if (!rst_n || !hw_on) begin
            ctrl_q    <= ctrl_t'(CTRL_DEF);
            m1_q      <= M1_DEF;
            m2_q      <= M2_DEF;
            r1_q      <= R_DEF;
            r2_q      <= R_DEF;
            cp1_q     <= CP_DEF;
            cp2_q     <= CP_DEF;
            div_since <= 1'b0;
            turbo_q   <= 1'b0;
        end else begin
            turbo_q <= 1'b0;
            if (frame_vld) begin
                casez (adr)
                    3'b?00: begin m1_q <= f_m; div_since <= 1'b1; end
                    3'b?01: begin m2_q <= f_m; div_since <= 1'b1; end
                    3'b010: begin r1_q <= f_r; cp1_q <= f_cp; div_since <= 1'b1; end
                    3'b011: begin r2_q <= f_r; cp2_q <= f_cp; div_since <= 1'b1; end
                    3'b110: begin
                        ctrl_q    <= f_ctrl;
                        turbo_q   <= f_ctrl.turbo & div_since;
                        div_since <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    p_hw_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_on |=> (ctrl_q == ctrl_t'(CTRL_DEF) && m1_q == M1_DEF && m2_q == M2_DEF));
    p_hold_no_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_vld && hw_on) |=> ($stable(ctrl_q) && $stable(m1_q) && $stable(m2_q)
                                   && $stable(r1_q) && $stable(r2_q)));
    p_turbo_bit_r12: assert property (@(posedge clk) disable iff (!rst_n)
        turbo_q |-> ctrl_q.turbo);
endmodule

// File: rtl/tri_wire_mode.sv
`timescale 1ns/1ps
// Resolves effective selects from register bits and the tri-level mode
// pin, picks the active divider set and derives power states.
module tri_wire_mode
    import tri_wire_cfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hw_on,
    input  logic            mode_drv,
    input  logic            mode_lvl,
    input  logic            reg_vco_hi,
    input  logic            reg_div_set1,
    input  logic            reg_in_cdma,
    input  logic            reg_powered,
    input  logic            reg_active,
    input  logic [M_W-1:0]  m1,
    input  logic [M_W-1:0]  m2,
    input  logic [R_W-1:0]  r1,
    input  logic [R_W-1:0]  r2,
    input  logic [CP_W-1:0] cp1,
    input  logic [CP_W-1:0] cp2,
    output logic            vco_hi,
    output logic            div_set1,
    output logic            in_cdma,
    output logic [M_W-1:0]  m_eff,
    output logic [R_W-1:0]  r_eff,
    output logic [CP_W-1:0] cp_eff,
    output logic            chip_on,
    output logic            path_on
);
    // Pin override of the three selects, then divider-set mux and power.
    always_comb begin
        vco_hi   = mode_drv ? mode_lvl : reg_vco_hi;
        div_set1 = mode_drv ? mode_lvl : reg_div_set1;
        in_cdma  = mode_drv ? mode_lvl : reg_in_cdma;
        m_eff    = div_set1 ? m1  : m2;
        r_eff    = div_set1 ? r1  : r2;
        cp_eff   = div_set1 ? cp1 : cp2;
        chip_on  = hw_on & reg_powered;
        path_on  = chip_on & reg_active;
    end

    p_pin_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_drv |-> (vco_hi == mode_lvl && div_set1 == mode_lvl && in_cdma == mode_lvl));
    p_path_needs_chip_r11: assert property (@(posedge clk) disable iff (!rst_n)
        path_on |-> chip_on);
    p_hw_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_on |-> !chip_on);
endmodule

// File: rtl/tri_wire_cfg.sv
`timescale 1ns/1ps
// Top of the three-wire configuration port: serial receiver, register
// file and mode resolution. Assumes hw_shdn_n_i is synchronous to clk.
module tri_wire_cfg
    import tri_wire_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hw_shdn_n_i,
    input  logic         sclk_i,
    input  logic         sdata_i,
    input  logic         sen_n_i,
    input  logic         mode_drv_i,
    input  logic         mode_lvl_i,
    output logic [12:0]  ctrl_o,
    output logic [13:0]  m1_o,
    output logic [13:0]  m2_o,
    output logic [10:0]  r1_o,
    output logic [10:0]  r2_o,
    output logic [1:0]   cp1_o,
    output logic [1:0]   cp2_o,
    output logic [13:0]  m_eff_o,
    output logic [10:0]  r_eff_o,
    output logic [1:0]   cp_eff_o,
    output logic         vco_hi_o,
    output logic         div_set1_o,
    output logic         in_cdma_o,
    output logic         fm_i_only_o,
    output logic         vco_bypass_o,
    output logic         lo_buf_on_o,
    output logic         lo_half_o,
    output logic         cp_pol_o,
    output logic         chip_on_o,
    output logic         path_on_o,
    output logic         turbo_start_o
);
    logic             frame_vld;
    logic [PAY_W-1:0] payload;
    ctrl_t            ctrl_q;

    tri_wire_rx #(.SYNC_STAGES(SYNC_STAGES)) rx_i (
        .clk(clk), .rst_n(rst_n), .hw_on(hw_shdn_n_i),
        .sclk(sclk_i), .sdata(sdata_i), .sen_n(sen_n_i),
        .frame_vld(frame_vld), .payload(payload)
    );

    tri_wire_regs regs_i (
        .clk(clk), .rst_n(rst_n), .hw_on(hw_shdn_n_i),
        .frame_vld(frame_vld), .payload(payload),
        .ctrl_q(ctrl_q), .m1_q(m1_o), .m2_q(m2_o), .r1_q(r1_o), .r2_q(r2_o),
        .cp1_q(cp1_o), .cp2_q(cp2_o), .turbo_q(turbo_start_o)
    );

    tri_wire_mode mode_i (
        .clk(clk), .rst_n(rst_n), .hw_on(hw_shdn_n_i),
        .mode_drv(mode_drv_i), .mode_lvl(mode_lvl_i),
        .reg_vco_hi(ctrl_q.vco_hi), .reg_div_set1(ctrl_q.div_set1),
        .reg_in_cdma(ctrl_q.in_cdma), .reg_powered(ctrl_q.powered),
        .reg_active(ctrl_q.active),
        .m1(m1_o), .m2(m2_o), .r1(r1_o), .r2(r2_o), .cp1(cp1_o), .cp2(cp2_o),
        .vco_hi(vco_hi_o), .div_set1(div_set1_o), .in_cdma(in_cdma_o),
        .m_eff(m_eff_o), .r_eff(r_eff_o), .cp_eff(cp_eff_o),
        .chip_on(chip_on_o), .path_on(path_on_o)
    );

    assign ctrl_o       = ctrl_q;
    assign fm_i_only_o  = ctrl_q.fm_i_only;
    assign vco_bypass_o = ctrl_q.vco_byp;
    assign lo_buf_on_o  = chip_on_o & ~ctrl_q.buf_off;
    assign lo_half_o    = ctrl_q.buf_half;
    assign cp_pol_o     = ctrl_q.cp_pol;
endmodule

// File: tb/tri_wire_cfg_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver pushes expected items, monitor pops and compares.
module tri_wire_cfg_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hw_shdn_n = 1'b1, sclk = 1'b0, sdata = 1'b0, sen_n = 1'b1;
    logic mode_drv = 1'b0, mode_lvl = 1'b0;
    logic [12:0] ctrl_o;
    logic [13:0] m1_o, m2_o, m_eff_o;
    logic [10:0] r1_o, r2_o, r_eff_o;
    logic [1:0]  cp1_o, cp2_o, cp_eff_o;
    logic vco_hi_o, div_set1_o, in_cdma_o, fm_i_only_o, vco_bypass_o;
    logic lo_buf_on_o, lo_half_o, cp_pol_o, chip_on_o, path_on_o, turbo_start_o;

    always #2 clk = ~clk;

    tri_wire_cfg dut_i (
        .clk(clk), .rst_n(rst_n), .hw_shdn_n_i(hw_shdn_n), .sclk_i(sclk),
        .sdata_i(sdata), .sen_n_i(sen_n), .mode_drv_i(mode_drv), .mode_lvl_i(mode_lvl),
        .ctrl_o(ctrl_o), .m1_o(m1_o), .m2_o(m2_o), .r1_o(r1_o), .r2_o(r2_o),
        .cp1_o(cp1_o), .cp2_o(cp2_o), .m_eff_o(m_eff_o), .r_eff_o(r_eff_o),
        .cp_eff_o(cp_eff_o), .vco_hi_o(vco_hi_o), .div_set1_o(div_set1_o),
        .in_cdma_o(in_cdma_o), .fm_i_only_o(fm_i_only_o), .vco_bypass_o(vco_bypass_o),
        .lo_buf_on_o(lo_buf_on_o), .lo_half_o(lo_half_o), .cp_pol_o(cp_pol_o),
        .chip_on_o(chip_on_o), .path_on_o(path_on_o), .turbo_start_o(turbo_start_o)
    );

    typedef struct { string tag; int sel; logic [31:0] exp; } item_t;
    item_t sb_q[$];
    event  ev_chk;
    int    n_chk = 0, n_err = 0, turbo_cnt = 0;
    bit    done = 1'b0;

    // Expected register model
    logic [12:0] e_ctrl;
    logic [13:0] e_m1, e_m2;
    logic [10:0] e_r1, e_r2;
    logic [1:0]  e_cp1, e_cp2;
    int          e_turbo = 0;

    always @(posedge clk) if (rst_n && turbo_start_o) turbo_cnt++;

    function automatic logic [31:0] actual(int sel);
        case (sel)
            0: return 32'(ctrl_o);   1: return 32'(m1_o);    2: return 32'(m2_o);
            3: return 32'(r1_o);     4: return 32'(r2_o);    5: return 32'(cp1_o);
            6: return 32'(cp2_o);    7: return 32'(m_eff_o); 8: return 32'(r_eff_o);
            9: return 32'(cp_eff_o);
            10: return 32'({vco_hi_o, div_set1_o, in_cdma_o});
            11: return 32'(chip_on_o); 12: return 32'(path_on_o);
            default: return 32'(turbo_cnt);
        endcase
    endfunction

    // Monitor: pops expected items and compares against the ports.
    initial forever begin
        @(ev_chk);
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_chk++;
            if (actual(it.sel) !== it.exp) begin
                n_err++;
                $display("FAIL %s sel=%0d act=%h exp=%h", it.tag, it.sel, actual(it.sel), it.exp);
            end
        end
    end

    task automatic expect_(string tag, int sel, logic [31:0] exp);
        item_t it;
        it.tag = tag; it.sel = sel; it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic flush();
        @(negedge clk);
        -> ev_chk;
        #0.5;
    endtask

    task automatic exp_regs(string tag);
        expect_(tag, 0, 32'(e_ctrl)); expect_(tag, 1, 32'(e_m1)); expect_(tag, 2, 32'(e_m2));
        expect_(tag, 3, 32'(e_r1));   expect_(tag, 4, 32'(e_r2)); expect_(tag, 5, 32'(e_cp1));
        expect_(tag, 6, 32'(e_cp2));  expect_(tag, 13, 32'(e_turbo));
        flush();
    endtask

    task automatic set_defaults();
        e_ctrl = 13'h0B57; e_m1 = 14'd10519; e_m2 = 14'd4269;
        e_r1 = 11'd492; e_r2 = 11'd492; e_cp1 = 2'b11; e_cp2 = 2'b11;
    endtask

    task automatic half();
        repeat (8) @(negedge clk);
    endtask

    // Driver: serial frame, n bits MSB first, optional initialisation edge.
    task automatic send(logic [17:0] w, int n, bit init);
        if (init) begin half(); sclk = 1'b1; half(); sclk = 1'b0; end
        half(); sen_n = 1'b0; half();
        for (int i = n - 1; i >= 0; i--) begin
            sdata = w[i]; half(); sclk = 1'b1; half(); sclk = 1'b0;
        end
        half(); sen_n = 1'b1;
        repeat (16) @(negedge clk);
    endtask

    function automatic logic [17:0] f_ctrl(logic [12:0] c);
        return {1'b0, 1'b1, c, 3'b110};
    endfunction
    function automatic logic [17:0] f_m(logic [13:0] m, bit second);
        return {1'b0, 1'b1, m, 1'b0, second};
    endfunction
    function automatic logic [17:0] f_r(logic [1:0] cp, logic [10:0] r, bit second);
        return {1'b0, 1'b1, cp, r, 2'b01, second};
    endfunction

    initial begin
        set_defaults();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: defaults
        exp_regs("R1");
        expect_("R1", 10, 3'b111); expect_("R1", 11, 1); expect_("R1", 12, 1);
        expect_("R1", 7, 32'(14'd10519)); flush();
        // R2: control write; turbo bit set but no divider write before it (R12)
        send(f_ctrl(13'h0B5F), 17, 1); e_ctrl = 13'h0B5F; exp_regs("R2");
        // R3: VCO dividers, odd value uses A2 as bit 0
        send(f_m(14'h2A5B, 0), 17, 1); e_m1 = 14'h2A5B;
        send(f_m(14'h1234, 1), 17, 1); e_m2 = 14'h1234; exp_regs("R3");
        // R12: control with turbo after divider write pulses once
        send(f_ctrl(13'h0B57), 17, 1); e_ctrl = 13'h0B57; e_turbo = 1; exp_regs("R12");
        send(f_ctrl(13'h0B57), 17, 1); exp_regs("R12");
        // R4: reference and pump pairs
        send(f_r(2'b01, 11'h3A5, 0), 17, 1); e_r1 = 11'h3A5; e_cp1 = 2'b01;
        send(f_r(2'b10, 11'h155, 1), 17, 1); e_r2 = 11'h155; e_cp2 = 2'b10; exp_regs("R4");
        // R12: control without turbo bit after divider writes, no pulse
        send(f_ctrl(13'h0957), 17, 1); e_ctrl = 13'h0957; exp_regs("R12");
        // R9: set selection via bit 8
        expect_("R9", 7, 32'(e_m1)); expect_("R9", 8, 32'(e_r1)); expect_("R9", 9, 32'(e_cp1));
        flush();
        send(f_ctrl(13'h0857), 17, 1); e_ctrl = 13'h0857; exp_regs("R9");
        expect_("R9", 7, 32'(e_m2)); expect_("R9", 8, 32'(e_r2)); expect_("R9", 9, 32'(e_cp2));
        expect_("R8", 10, 3'b101); flush();
        // R8: mode pin override
        mode_drv = 1'b1; mode_lvl = 1'b0; repeat (2) @(negedge clk);
        expect_("R8", 10, 3'b000); expect_("R8", 7, 32'(e_m2)); flush();
        mode_lvl = 1'b1; repeat (2) @(negedge clk);
        expect_("R8", 10, 3'b111); expect_("R8", 7, 32'(e_m1)); flush();
        mode_drv = 1'b0; repeat (2) @(negedge clk);
        expect_("R8", 10, 3'b101); flush();
        // R5: start bit 0
        send({1'b0, 1'b0, 13'h0000, 3'b110}, 17, 1); exp_regs("R5");
        // R6: 16 and 18 bit frames
        send(f_ctrl(13'h0000), 16, 1); exp_regs("R6");
        send({1'b1, f_ctrl(13'h0000)}, 18, 1); exp_regs("R6");
        // R7: no initialisation edge
        send(f_ctrl(13'h0000), 17, 0); exp_regs("R7");
        // R13: unused address
        send({1'b0, 1'b1, 13'h0000, 3'b111}, 17, 1); exp_regs("R13");
        // R12: divider then turbo control
        send(f_m(14'h3FFE, 0), 17, 1); e_m1 = 14'h3FFE;
        send(f_ctrl(13'h0B57), 17, 1); e_ctrl = 13'h0B57; e_turbo = 2; exp_regs("R12");
        // R11: register power-down keeps port alive
        send(f_ctrl(13'h0B56), 17, 1); e_ctrl = 13'h0B56;
        expect_("R11", 11, 0); expect_("R11", 12, 0); exp_regs("R11");
        send(f_m(14'h0ABC, 1), 17, 1); e_m2 = 14'h0ABC; exp_regs("R11");
        send(f_ctrl(13'h0B55), 17, 1); e_ctrl = 13'h0B55; e_turbo = 3;
        expect_("R11", 11, 1); expect_("R11", 12, 0); exp_regs("R11");
        // R10: hardware shutdown
        hw_shdn_n = 1'b0; repeat (3) @(negedge clk);
        set_defaults(); expect_("R10", 11, 0); exp_regs("R10");
        send(f_m(14'h1234, 0), 17, 1); exp_regs("R10");
        hw_shdn_n = 1'b1; repeat (4) @(negedge clk);
        expect_("R10", 11, 1); expect_("R10", 12, 1); exp_regs("R10");
        send(f_m(14'h0777, 0), 17, 1); e_m1 = 14'h0777; exp_regs("R10");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule